// File: doc/BRIEF.md
# Serial Converter Frame Reader

This block is the host side of a three-wire link to a 12-bit sampling converter. It drives an active-low chip select and a serial clock, and it reads the serial data returned by the converter. A frame starts on a one-cycle `start` request, or back to back while `free_run` is held high. Each frame has a programmable setup gap, then sixteen serial clock periods. The converter returns four zero bits and then twelve result bits, most significant first.

At the end of a frame the block presents the 12-bit result together with a one-cycle strobe. If any of the four leading bits was read as one, it sets a sticky framing-error flag. All timing is counted in system clock cycles:
- the half period of the serial clock,
- the gap from the chip-select fall to the first serial clock fall,
- the quiet gap after a frame.

A request that arrives while a frame or a quiet gap is running is remembered. It is served as soon as the gap has run out.

Top module: `adc_frame_reader`

## Requirements
- R1: While reset is active and in the first cycle after it, `cs_n` and `sclk` are 1, `result_valid` and `frame_err` are 0, and `result` is 0.
- R2: A frame (`cs_n` driven low) begins only after a `start` pulse, a pending request, or while `free_run` is 1. With `start` and `free_run` both 0, `cs_n` stays high.
- R3: `sclk` is 1 whenever `cs_n` is 1. The first `sclk` fall comes max(`setup_cycles`,1) system cycles after the `cs_n` fall.
- R4: Each frame has exactly 16 falling edges of `sclk`. Every low phase and every high phase in the frame lasts max(`half_div`,1) system cycles. `cs_n` returns high in the cycle in which `sclk` rises at the end of the 16th low phase.
- R5: `sdata` is sampled in the cycle in which `sclk` is driven low. The first sample is the frame's bit 15. The samples are frame bits 15 down to 0: bits 15..12 are the leading zeros, and bits 11..0 are the result with the MSB first.
- R6: `result_valid` is high for exactly one cycle, the cycle in which `cs_n` returns high. In that cycle `result` equals frame bits 11..0, and it holds until the next strobe.
- R7: Between frames `cs_n` stays high for at least max(`quiet_cycles`,1) cycles. When the next frame is already requested it stays high for exactly max(`quiet_cycles`,1)+1 cycles.
- R8: A `start` that arrives during a frame or during the quiet gap is held. The new frame then begins max(`quiet_cycles`,1)+1 cycles after `cs_n` rises. Several such requests before that point give one frame only.
- R9: `frame_err` becomes 1 together with the strobe of any frame whose bits 15..12 are not all zero, and it then stays 1 until reset. The result of that frame is still delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request for a single frame |
| free_run | input | 1 | Start frames back to back while high |
| half_div | input | DIV_W | Serial clock half period in system cycles (0 acts as 1) |
| setup_cycles | input | GUARD_W | Cycles from the chip-select fall to the first clock fall (0 acts as 1) |
| quiet_cycles | input | GUARD_W | Minimum quiet cycles after a frame (0 acts as 1) |
| sdata | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles high |
| result | output | DATA_BITS | Last converted value |
| result_valid | output | 1 | One-cycle strobe for a new result |
| frame_err | output | 1 | Sticky flag for a nonzero leading bit |

## Verification
The quiet-gap property compares the measured high time of `cs_n` with the `quiet_cycles` input as it is at the moment of the next fall. It therefore assumes that the configuration inputs do not change while a frame or a quiet gap is running.

The bench changes `half_div`, `setup_cycles` and `quiet_cycles` only after it has held `free_run` low and waited well past the quiet gap. Its converter model changes `sdata` only a short delay after each `sclk` fall, so the data never moves in the cycle in which the block samples it.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

   typedef enum logic [2:0] {
      RD_IDLE  = 3'd0,
      RD_SETUP = 3'd1,
      RD_LOW   = 3'd2,
      RD_HIGH  = 3'd3,
      RD_QUIET = 3'd4
   } rd_state_t;

endpackage

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         done
);

   logic [W-1:0] cnt_q;

   // A load of N keeps done low for N-1 cycles; a load of 0 behaves as 1.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= (load_val == '0) ? '0 : load_val - W'(1);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - W'(1);
      end
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture #(
   parameter int DATA_BITS = 12,
   parameter int ZERO_BITS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 shift_en,
   input  logic                 commit,
   input  logic                 sdata,
   output logic [DATA_BITS-1:0] result,
   output logic                 valid,
   output logic                 err
);

   localparam int FRAME_BITS = DATA_BITS + ZERO_BITS;

   logic [FRAME_BITS-1:0] shreg_q;
   logic [DATA_BITS-1:0]  res_q;
   logic                  valid_q;
   logic                  err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg_q <= '0;
         res_q   <= '0;
         valid_q <= 1'b0;
      end else begin
         if (shift_en) begin
            shreg_q <= {shreg_q[FRAME_BITS-2:0], sdata};
         end
         if (commit) begin
            res_q <= shreg_q[DATA_BITS-1:0];
         end
         valid_q <= commit;
      end
   end

   generate
      if (ZERO_BITS > 0) begin : g_zero_chk
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               err_q <= 1'b0;
            end else if (commit && (shreg_q[FRAME_BITS-1:DATA_BITS] != '0)) begin
               err_q <= 1'b1;
            end
         end
      end else begin : g_no_zero_chk
         assign err_q = 1'b0;
      end
   endgenerate

   assign result = res_q;
   assign valid  = valid_q;
   assign err    = err_q;

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
   import adc_rd_pkg::*;
#(
   parameter int DATA_BITS = 12,
   parameter int ZERO_BITS = 4,
   parameter int DIV_W     = 8,
   parameter int GUARD_W   = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 free_run,
   input  logic [DIV_W-1:0]     half_div,
   input  logic [GUARD_W-1:0]   setup_cycles,
   input  logic [GUARD_W-1:0]   quiet_cycles,
   input  logic                 sdata,
   output logic                 cs_n,
   output logic                 sclk,
   output logic [DATA_BITS-1:0] result,
   output logic                 result_valid,
   output logic                 frame_err
);

   localparam int FRAME_BITS = DATA_BITS + ZERO_BITS;
   localparam int EDGE_W     = $clog2(FRAME_BITS + 1);
   localparam int CNT_W      = (DIV_W > GUARD_W) ? DIV_W : GUARD_W;

   generate
      if (DATA_BITS < 2 || ZERO_BITS < 0 || DIV_W < 1 || GUARD_W < 1) begin : g_bad_cfg
         $error("adc_frame_reader: invalid parameter set");
      end
   endgenerate

   rd_state_t         state_q, state_d;
   logic              cs_q, cs_d;
   logic              sclk_q, sclk_d;
   logic              pend_q, pend_d;
   logic [EDGE_W-1:0] edge_q, edge_d;
   logic              ld;
   logic [CNT_W-1:0]  ld_val;
   logic              t_done;
   logic              shift_en;
   logic              commit;

   always_comb begin
      state_d  = state_q;
      cs_d     = cs_q;
      sclk_d   = sclk_q;
      edge_d   = edge_q;
      pend_d   = pend_q | (start && (state_q != RD_IDLE));
      ld       = 1'b0;
      ld_val   = '0;
      shift_en = 1'b0;
      commit   = 1'b0;
      case (state_q)
         RD_IDLE: begin
            if (start || pend_q || free_run) begin
               state_d = RD_SETUP;
               cs_d    = 1'b0;
               pend_d  = 1'b0;
               ld      = 1'b1;
               ld_val  = CNT_W'(setup_cycles);
            end
         end
         RD_SETUP: begin
            if (t_done) begin
               state_d  = RD_LOW;
               sclk_d   = 1'b0;
               shift_en = 1'b1;
               edge_d   = EDGE_W'(1);
               ld       = 1'b1;
               ld_val   = CNT_W'(half_div);
            end
         end
         RD_LOW: begin
            if (t_done) begin
               sclk_d = 1'b1;
               ld     = 1'b1;
               if (edge_q == EDGE_W'(FRAME_BITS)) begin
                  state_d = RD_QUIET;
                  cs_d    = 1'b1;
                  commit  = 1'b1;
                  ld_val  = CNT_W'(quiet_cycles);
               end else begin
                  state_d = RD_HIGH;
                  ld_val  = CNT_W'(half_div);
               end
            end
         end
         RD_HIGH: begin
            if (t_done) begin
               state_d  = RD_LOW;
               sclk_d   = 1'b0;
               shift_en = 1'b1;
               edge_d   = edge_q + EDGE_W'(1);
               ld       = 1'b1;
               ld_val   = CNT_W'(half_div);
            end
         end
         RD_QUIET: begin
            if (t_done) begin
               state_d = RD_IDLE;
            end
         end
         default: state_d = RD_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= RD_IDLE;
         cs_q    <= 1'b1;
         sclk_q  <= 1'b1;
         pend_q  <= 1'b0;
         edge_q  <= '0;
      end else begin
         state_q <= state_d;
         cs_q    <= cs_d;
         sclk_q  <= sclk_d;
         pend_q  <= pend_d;
         edge_q  <= edge_d;
      end
   end

   adc_rd_timer #(.W(CNT_W)) timer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld),
      .load_val (ld_val),
      .done     (t_done)
   );

   adc_rd_capture #(.DATA_BITS(DATA_BITS), .ZERO_BITS(ZERO_BITS)) capture_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .commit   (commit),
      .sdata    (sdata),
      .result   (result),
      .valid    (result_valid),
      .err      (frame_err)
   );

   assign cs_n = cs_q;
   assign sclk = sclk_q;

endmodule

// File: rtl/adc_frame_reader_chk.sv
module adc_frame_reader_chk #(
   parameter int GUARD_W    = 8,
   parameter int FRAME_BITS = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cs_n,
   input logic               sclk,
   input logic               result_valid,
   input logic               frame_err,
   input logic [GUARD_W-1:0] quiet_cycles
);

   localparam int FC_W = $clog2(FRAME_BITS + 1) + 1;

   logic              sclk_q;
   logic              cs_q;
   logic [FC_W-1:0]   falls_q;
   logic [GUARD_W+1:0] gap_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sclk_q  <= 1'b1;
         cs_q    <= 1'b1;
         falls_q <= '0;
         gap_q   <= '1;
      end else begin
         sclk_q <= sclk;
         cs_q   <= cs_n;
         if (!cs_n && cs_q) begin
            falls_q <= '0;
         end else if (!cs_n && sclk_q && !sclk && (falls_q != '1)) begin
            falls_q <= falls_q + FC_W'(1);
         end
         if (!cs_n) begin
            gap_q <= '0;
         end else if (gap_q != '1) begin
            gap_q <= gap_q + (GUARD_W+2)'(1);
         end
      end
   end

   // R3
   sclk_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> sclk);

   // R3
   setup_before_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> sclk);

   // R4
   sixteen_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> (falls_q == FC_W'(FRAME_BITS)));

   // R6
   valid_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> $rose(cs_n));

   // R7
   quiet_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> (gap_q >= {2'b00, quiet_cycles}));

   // R9
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |=> frame_err);

endmodule

bind adc_frame_reader adc_frame_reader_chk #(
   .GUARD_W    (GUARD_W),
   .FRAME_BITS (DATA_BITS + ZERO_BITS)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .cs_n         (cs_n),
   .sclk         (sclk),
   .result_valid (result_valid),
   .frame_err    (frame_err),
   .quiet_cycles (quiet_cycles)
);

// File: tb/adc_frame_reader_tb_top.sv
`timescale 1ns/1ps
module adc_frame_reader_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        free_run = 1'b0;
   logic [7:0]  half_div = 8'd1;
   logic [7:0]  setup_cycles = 8'd1;
   logic [7:0]  quiet_cycles = 8'd1;
   logic        sdata = 1'b1;
   logic        cs_n;
   logic        sclk;
   logic [11:0] result;
   logic        result_valid;
   logic        frame_err;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   logic [15:0] tx_word = 16'h0000;
   int bidx = 15;

   int prev_cs = 1, prev_sclk = 1;
   int gap_run = 0, last_gap = 0, setup_run = 0, last_setup = 0, in_setup = 0;
   int falls = 0, phase_run = 0, nframes = 0;
   int lo_min = 1000, lo_max = 0, hi_min = 1000, hi_max = 0;

   always #10 clk = ~clk;

   adc_frame_reader dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .free_run     (free_run),
      .half_div     (half_div),
      .setup_cycles (setup_cycles),
      .quiet_cycles (quiet_cycles),
      .sdata        (sdata),
      .cs_n         (cs_n),
      .sclk         (sclk),
      .result       (result),
      .result_valid (result_valid),
      .frame_err    (frame_err)
   );

   // Converter model: bit 15 after the select fall, next bit after each clock fall.
   always @(negedge cs_n or negedge sclk or posedge cs_n) begin
      if (cs_n) begin
         #2 sdata = 1'b1;
      end else begin
         if (sclk) bidx = 15;
         else if (bidx > 0) bidx = bidx - 1;
         #2 sdata = tx_word[bidx];
      end
   end

   // Timing monitor, sampled away from the active edge.
   always @(negedge clk) begin
      if (rst_n) begin
         if (cs_n) begin
            if (prev_cs == 0) begin
               if (phase_run < lo_min) lo_min = phase_run;
               if (phase_run > lo_max) lo_max = phase_run;
               gap_run = 1;
            end else gap_run = gap_run + 1;
         end else if (prev_cs == 1) begin
            last_gap = gap_run; nframes = nframes + 1;
            setup_run = 1; in_setup = 1; falls = 0;
            lo_min = 1000; lo_max = 0; hi_min = 1000; hi_max = 0;
         end else if (in_setup == 1) begin
            if (sclk) setup_run = setup_run + 1;
            else begin last_setup = setup_run; in_setup = 0; falls = 1; phase_run = 1; end
         end else if (int'(sclk) == prev_sclk) begin
            phase_run = phase_run + 1;
         end else begin
            if (prev_sclk == 1) begin
               if (phase_run < hi_min) hi_min = phase_run;
               if (phase_run > hi_max) hi_max = phase_run;
            end else begin
               if (phase_run < lo_min) lo_min = phase_run;
               if (phase_run > lo_max) lo_max = phase_run;
            end
            if (!sclk) falls = falls + 1;
            phase_run = 1;
         end
      end
      prev_cs = int'(cs_n);
      prev_sclk = int'(sclk);
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; start = 1'b0; free_run = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R1 reset state
      chk(cs_n && sclk && !result_valid && !frame_err && result == 12'd0,
          "R1 reset state", {cs_n, sclk, result_valid, frame_err}, 4'b1100);
   endtask

   task automatic pulse_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_valid();
      int n = 0;
      do begin @(negedge clk); n++; end while (!result_valid && n < 5000);
      #1;
      chk(n < 5000, "R2 frame completes", n, 0);
   endtask

   task automatic check_frame(input logic [15:0] w, input int hh, input int ss, input string tag);
      // R5 R6 result is frame bits 11..0
      chk(result == w[11:0], {tag, " R5/R6 result"}, result, w[11:0]);
      // R4 sixteen falls and exact phase widths
      chk(falls == 16, {tag, " R4 falls"}, falls, 16);
      chk(lo_min == hh && lo_max == hh, {tag, " R4 low phase"}, lo_max, hh);
      chk(hi_min == hh && hi_max == hh, {tag, " R4 high phase"}, hi_max, hh);
      // R3 setup gap
      chk(last_setup == ss, {tag, " R3 setup"}, last_setup, ss);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] w1, w2;
      int n0;
      do_reset();

      // R2 no frame without a request
      n0 = nframes;
      repeat (60) @(negedge clk);
      #1;
      chk(nframes == n0 && cs_n, "R2 idle without request", nframes - n0, 0);

      // Sweep: half period x setup x quiet, two back-to-back frames each
      for (int h = 0; h < 4; h++) begin
         for (int si = 0; si < 3; si++) begin
            for (int qi = 0; qi < 3; qi++) begin
               int sv, qv, hh, ss, qq;
               sv = (si == 2) ? 3 : si;
               qv = (qi == 0) ? 0 : ((qi == 1) ? 2 : 5);
               hh = (h == 0) ? 1 : h;
               ss = (sv == 0) ? 1 : sv;
               qq = (qv == 0) ? 1 : qv;
               free_run = 1'b0;
               repeat (30) @(negedge clk);
               half_div = 8'(h); setup_cycles = 8'(sv); quiet_cycles = 8'(qv);
               w1 = {4'h0, 12'((h * 9 + si * 3 + qi) * 331 + 17)};
               w2 = {4'h0, ~w1[11:0]};
               tx_word = w1;
               free_run = 1'b1;
               wait_valid();
               tx_word = w2;
               check_frame(w1, hh, ss, "sweep f1");
               @(negedge clk); #1;
               // R6 strobe lasts one cycle
               chk(!result_valid, "R6 strobe width", result_valid, 0);
               wait_valid();
               free_run = 1'b0;
               check_frame(w2, hh, ss, "sweep f2");
               // R7 exact gap when the next frame is already requested
               chk(last_gap == qq + 1, "R7 quiet gap", last_gap, qq + 1);
            end
         end
      end
      #1;
      chk(!frame_err, "R9 no error on clean frames", frame_err, 0);

      // R8 pending requests
      repeat (30) @(negedge clk);
      half_div = 8'd1; setup_cycles = 8'd1; quiet_cycles = 8'd4;
      tx_word = 16'h0A5C;
      n0 = nframes;
      pulse_start();
      repeat (10) @(negedge clk);
      pulse_start();
      repeat (3) @(negedge clk);
      pulse_start();
      wait_valid();
      check_frame(16'h0A5C, 1, 1, "R8 first");
      tx_word = 16'h03C1;
      wait_valid();
      check_frame(16'h03C1, 1, 1, "R8 held");
      chk(last_gap == 5, "R8 held start gap", last_gap, 5);
      repeat (300) @(negedge clk);
      #1;
      chk(nframes == n0 + 2, "R8 requests merge", nframes - n0, 2);
      tx_word = 16'h0777;
      pulse_start();
      wait_valid();
      tx_word = 16'h0888;
      @(negedge clk);
      pulse_start();
      wait_valid();
      check_frame(16'h0888, 1, 1, "R8 quiet start");
      chk(last_gap == 5, "R8 start in quiet gap", last_gap, 5);

      // R9 every leading nibble, sticky over a following clean frame
      for (int z = 0; z < 16; z++) begin
         logic [11:0] v;
         do_reset();
         half_div = 8'd1; setup_cycles = 8'd1; quiet_cycles = 8'd1;
         v = 12'(z * 273 + 9);
         tx_word = {4'(z), v};
         pulse_start();
         wait_valid();
         chk(result == v, "R9 result delivered", result, v);
         chk(frame_err == (z != 0), "R9 error flag", frame_err, (z != 0));
         tx_word = {4'h0, ~v};
         repeat (5) @(negedge clk);
         pulse_start();
         wait_valid();
         chk(result == ~v, "R5 clean frame after error", result, ~v);
         chk(frame_err == (z != 0), "R9 error sticky", frame_err, (z != 0));
      end

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule